// File: doc/BRIEF.md
# Serial ADC Sample Read Controller

This block is the master side of a three-wire link to a 12-bit serial converter. A one-cycle trigger starts a read: the block pulls the active-low select line down, waits a setup interval, and then drives exactly sixteen serial clock periods. The converter changes its data line after each falling clock edge. The controller samples that line on the following rising edge, half a period later. When the frame ends, the low twelve of the sixteen captured bits are presented with a one-cycle valid strobe. The select line is then held high for an enforced quiet interval before another frame may begin.

All timing is counted in system clock cycles and set by parameters: the serial clock half period, the select-to-clock setup, the minimum select-high time, the time the converter needs to release its data line, and the post-release quiet time. The requested half period is clamped at elaboration so that the serial clock stays between 10 kHz and 12 MHz for the given system clock frequency. Equal high and low phases keep the duty cycle at 50%.

A trigger that arrives while a frame or its quiet interval is running is remembered and served once the interval ends. Any number of such triggers collapse into one extra frame.

Top module: `adc_rd_ctrl`

## Requirements
- R1: During and right after synchronous reset, select is high, serial clock is high, and busy and valid are low.
- R2: A trigger seen on an edge while idle drives select low on that same edge. Busy stays high from then until the final quiet interval ends with no read pending, and it is high whenever select is low.
- R3: While select is high the serial clock is high. The first falling clock edge comes exactly SETUP_CYC cycles after select falls.
- R4: Each frame contains exactly FRAME_BITS (16) falling serial clock edges. Every low phase, and every high phase between two falling edges of a frame, lasts exactly the effective half period.
- R5: The effective half period is the parameter SCLK_HALF clamped to the range ceil(CLK_HZ/24e6) to floor(CLK_HZ/2e4). At 200 MHz, a request of 4 gives 9 cycles.
- R6: The data input is sampled once on each rising serial clock edge of a frame. The first sample is the most significant bit of a 16-bit word. The result is the last 12 samples, with the earliest in bit 11, so the first four samples are ignored.
- R7: Valid is a single-cycle pulse, high in the cycle in which select has just returned high, and the result is on the data output in that cycle.
- R8: After a frame, select stays high for at least POST_CYC = max(REL_CYC + QUIET_CYC, CSH_CYC) cycles. With a read pending it falls again after exactly POST_CYC + 1 cycles.
- R9: A trigger during a frame or a quiet interval is held and served once after that interval. Several such triggers produce only one additional frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Read request pulse |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles high |
| busy_o | output | 1 | Frame, quiet interval or pending read in progress |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | DATA_BITS | Conversion result |

## Verification
Some properties are checked on every cycle: the clock idles high under a released select, busy covers every low-select cycle, each low phase and each in-frame high phase matches the effective half period, each frame carries sixteen falling edges, the select-high gap is at least the quiet length, and valid is a single pulse that lines up with select returning high. Other behaviour can only be shown by the bench scenarios. These cover the data path, which uses a converter model that shifts a known word out on falling edges and is checked against queued expected values with nonzero leading bits. They also cover the exact setup count, the clamp of a too-fast divider request, the exact back-to-back spacing, and the collapsing of repeated triggers made during a frame or a quiet interval.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam longint unsigned SCLK_FMAX_HZ = 64'd12_000_000;
    localparam longint unsigned SCLK_FMIN_HZ = 64'd10_000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_GAP
    } rd_state_e;

    typedef struct packed {
        logic cs_n;
        logic sclk;
    } bus_pins_t;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Half period in system cycles, kept inside the legal serial clock band.
    function automatic int unsigned clamp_half(int unsigned clk_hz, int unsigned req);
        longint unsigned lo;
        longint unsigned hi;
        longint unsigned r;
        lo = (longint'(clk_hz) + 2 * SCLK_FMAX_HZ - 1) / (2 * SCLK_FMAX_HZ);
        hi = longint'(clk_hz) / (2 * SCLK_FMIN_HZ);
        if (lo == 0) lo = 1;
        if (hi < lo) hi = lo;
        r = longint'(req);
        if (r < lo) r = lo;
        if (r > hi) r = hi;
        return int'(r);
    endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         din,
    output logic [N-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (en)
            q <= {q[N-2:0], din};
    end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
    parameter int unsigned CLK_HZ     = 200_000_000,
    parameter int unsigned SCLK_HALF  = 10,
    parameter int unsigned SETUP_CYC  = 2,
    parameter int unsigned CSH_CYC    = 2,
    parameter int unsigned REL_CYC    = 5,
    parameter int unsigned QUIET_CYC  = 10,
    parameter int unsigned FRAME_BITS = 16,
    parameter int unsigned DATA_BITS  = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 trig,
    input  logic                 sdata_i,
    output logic                 cs_n_o,
    output logic                 sclk_o,
    output logic                 busy_o,
    output logic                 valid_o,
    output logic [DATA_BITS-1:0] data_o
);
    import adc_rd_pkg::*;

    localparam int unsigned HALF_EFF = clamp_half(CLK_HZ, SCLK_HALF);
    localparam int unsigned POST_CYC = max2(REL_CYC + QUIET_CYC, CSH_CYC);
    localparam int unsigned TMAX     = max2(max2(HALF_EFF, POST_CYC), SETUP_CYC);
    localparam int unsigned CW       = $clog2(TMAX + 1);
    localparam int unsigned BW       = $clog2(FRAME_BITS + 1);

    rd_state_e          st_q, st_d;
    bus_pins_t          pins_q, pins_d;
    logic               pend_q;
    logic [BW-1:0]      bits_q;
    logic               t_load;
    logic [CW-1:0]      t_val;
    logic               t_zero;
    logic               capture;
    logic               last_bit;
    logic               frame_done;
    logic [FRAME_BITS-1:0] shreg;
    logic               valid_q;
    logic [DATA_BITS-1:0] data_q;

    adc_rd_timer #(.W(CW)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    adc_rd_shift #(.N(FRAME_BITS)) shift_i (
        .clk (clk),
        .rst (rst),
        .en  (capture),
        .din (sdata_i),
        .q   (shreg)
    );

    assign last_bit   = (bits_q == BW'(FRAME_BITS));
    assign capture    = (st_q == ST_LOW) && t_zero;
    assign frame_done = (st_q == ST_HIGH) && t_zero && last_bit;

    always_comb begin
        st_d   = st_q;
        t_load = 1'b0;
        t_val  = '0;
        unique case (st_q)
            ST_IDLE: if (trig || pend_q) begin
                st_d   = ST_SETUP;
                t_load = 1'b1;
                t_val  = CW'(SETUP_CYC - 1);
            end
            ST_SETUP: if (t_zero) begin
                st_d   = ST_LOW;
                t_load = 1'b1;
                t_val  = CW'(HALF_EFF - 1);
            end
            ST_LOW: if (t_zero) begin
                st_d   = ST_HIGH;
                t_load = 1'b1;
                t_val  = CW'(HALF_EFF - 1);
            end
            ST_HIGH: if (t_zero) begin
                t_load = 1'b1;
                if (last_bit) begin
                    st_d  = ST_GAP;
                    t_val = CW'(POST_CYC - 1);
                end else begin
                    st_d  = ST_LOW;
                    t_val = CW'(HALF_EFF - 1);
                end
            end
            ST_GAP: if (t_zero) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pins_d.cs_n = !(st_d == ST_SETUP || st_d == ST_LOW || st_d == ST_HIGH);
        pins_d.sclk = (st_d != ST_LOW);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            pins_q  <= '{cs_n: 1'b1, sclk: 1'b1};
            pend_q  <= 1'b0;
            bits_q  <= '0;
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            st_q    <= st_d;
            pins_q  <= pins_d;
            valid_q <= frame_done;
            if (frame_done)
                data_q <= shreg[DATA_BITS-1:0];
            if (st_q == ST_IDLE)
                pend_q <= 1'b0;
            else if (trig)
                pend_q <= 1'b1;
            if (st_q == ST_SETUP)
                bits_q <= '0;
            else if (capture)
                bits_q <= bits_q + 1'b1;
        end
    end

    assign cs_n_o  = pins_q.cs_n;
    assign sclk_o  = pins_q.sclk;
    assign busy_o  = (st_q != ST_IDLE) || pend_q;
    assign valid_o = valid_q;
    assign data_o  = data_q;
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
    parameter int unsigned HALF_EFF   = 9,
    parameter int unsigned POST_CYC   = 15,
    parameter int unsigned FRAME_BITS = 16
) (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sclk,
    input logic busy,
    input logic valid
);
    int unsigned low_run;
    int unsigned high_run;
    int unsigned sel_hi_run;
    int unsigned falls;
    logic        sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run    <= 0;
            high_run   <= 0;
            sel_hi_run <= POST_CYC;
            falls      <= 0;
            sclk_d     <= 1'b1;
        end else begin
            sclk_d   <= sclk;
            low_run  <= sclk ? 0 : low_run + 1;
            high_run <= sclk ? high_run + 1 : 0;
            if (!cs_n)
                sel_hi_run <= 0;
            else if (sel_hi_run < POST_CYC)
                sel_hi_run <= sel_hi_run + 1;
            if (cs_n)
                falls <= 0;
            else if (sclk_d && !sclk)
                falls <= falls + 1;
        end
    end

    p_busy_frame_r2: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy);

    p_sclk_idle_high_r3: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);

    p_low_phase_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> (low_run == HALF_EFF));

    p_high_phase_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(sclk) && falls != 0) |-> (high_run == HALF_EFF));

    p_frame_edges_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> (falls == FRAME_BITS));

    p_valid_at_end_r7: assert property (@(posedge clk) disable iff (rst)
        valid |-> $rose(cs_n));

    p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (sel_hi_run >= POST_CYC));
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
    .HALF_EFF   (HALF_EFF),
    .POST_CYC   (POST_CYC),
    .FRAME_BITS (FRAME_BITS)
) chk_i (
    .clk   (clk),
    .rst   (rst),
    .cs_n  (cs_n_o),
    .sclk  (sclk_o),
    .busy  (busy_o),
    .valid (valid_o)
);

// File: tb/adc_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_rd_ctrl_tb_top;
    // Expected values worked out from the requirements for the parameters below.
    localparam int EXP_HALF  = 9;   // R5: request 4 at 200 MHz clamps to ceil(200/24)
    localparam int EXP_SETUP = 2;   // R3
    localparam int EXP_POST  = 15;  // R8: max(5 + 10, 2)

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig = 1'b0;
    logic sdata = 1'b0;
    logic cs_n, sclk, busy, valid;
    logic [11:0] data;

    adc_rd_ctrl #(
        .CLK_HZ(200_000_000), .SCLK_HALF(4), .SETUP_CYC(2), .CSH_CYC(2),
        .REL_CYC(5), .QUIET_CYC(10), .FRAME_BITS(16), .DATA_BITS(12)
    ) dut_i (
        .clk(clk), .rst(rst), .trig(trig), .sdata_i(sdata),
        .cs_n_o(cs_n), .sclk_o(sclk), .busy_o(busy), .valid_o(valid), .data_o(data)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] word_q[$];
    logic [11:0] exp_q[$];
    logic [15:0] cur_word = '0;
    int bitk = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Converter model: new bit after each falling clock edge, MSB first.
    always @(negedge cs_n) begin
        cur_word = (word_q.size() != 0) ? word_q.pop_front() : 16'h0;
        bitk = 0;
    end
    always @(negedge sclk) begin
        if (!cs_n) begin
            bitk++;
            if (bitk <= 16) sdata = cur_word[16 - bitk];
        end
    end

    // Monitor and scoreboard, sampled between clock edges.
    logic p_cs = 1'b1, p_sclk = 1'b1;
    int low_len = 0, high_len = 0, cl_cnt = 0, hi_len = 100, falls = 0;
    int frames = 0, last_gap = 0;

    always @(negedge clk) begin
        if (rst) begin
            p_cs = 1'b1; p_sclk = 1'b1; low_len = 0; high_len = 0;
            cl_cnt = 0; hi_len = 100; falls = 0;
        end else begin
            if (valid) begin
                frames++;
                chk(cs_n && !p_cs, "R7 valid with select release", cs_n, 1);
                if (exp_q.size() == 0)
                    chk(1'b0, "R7 unexpected valid", data, 0);
                else begin
                    logic [11:0] e;
                    e = exp_q.pop_front();
                    chk(data == e, "R6 result word", data, e);
                end
            end
            if (!cs_n && p_cs) begin
                last_gap = hi_len;
                chk(hi_len >= EXP_POST, "R8 quiet before select", hi_len, EXP_POST);
                chk(sclk, "R3 clock high at select fall", sclk, 1);
                cl_cnt = 0;
                falls = 0;
            end
            if (cs_n && !p_cs)
                chk(falls == 16, "R4 falling edges per frame", falls, 16);
            if (!sclk && p_sclk) begin
                if (falls == 0)
                    chk(cl_cnt == EXP_SETUP, "R3 setup to first edge", cl_cnt, EXP_SETUP);
                else
                    chk(high_len == EXP_HALF, "R4 high phase", high_len, EXP_HALF);
                falls++;
            end
            if (sclk && !p_sclk)
                chk(low_len == EXP_HALF, "R4 R5 low phase", low_len, EXP_HALF);
            if (!cs_n) cl_cnt++;
            low_len  = sclk ? 0 : low_len + 1;
            high_len = sclk ? high_len + 1 : 0;
            hi_len   = cs_n ? hi_len + 1 : 0;
            p_cs = cs_n;
            p_sclk = sclk;
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    task automatic queue_read(input logic [11:0] v, input logic [3:0] lead);
        word_q.push_back({lead, v});
        exp_q.push_back(v);
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", frames, 0);
        summary();
        $finish;
    end

    initial begin
        int f0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(cs_n == 1'b1 && sclk == 1'b1, "R1 pins in reset", {cs_n, sclk}, 3);
        chk(busy == 1'b0 && valid == 1'b0, "R1 status in reset", {busy, valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n && sclk && !busy && !valid, "R1 after reset", {cs_n, sclk, busy, valid}, 12);

        // R2 R6: single read, nonzero leading bits ignored
        queue_read(12'hA5C, 4'h9);
        pulse_trig();
        chk(!cs_n && busy, "R2 select falls on trigger edge", {cs_n, busy}, 1);
        wait_idle();
        chk(frames == 1, "R2 one frame", frames, 1);

        // R6: several data patterns
        queue_read(12'h000, 4'hF); pulse_trig(); wait_idle();
        queue_read(12'hFFF, 4'h0); pulse_trig(); wait_idle();
        queue_read(12'h801, 4'h6); pulse_trig(); wait_idle();
        queue_read(12'h3C5, 4'hA); pulse_trig(); wait_idle();
        chk(frames == 5, "R6 pattern frames", frames, 5);

        // R9: triggers during a frame collapse into one pending read
        f0 = frames;
        queue_read(12'h123, 4'h1);
        queue_read(12'h456, 4'h2);
        pulse_trig();
        repeat (20) @(negedge clk);
        pulse_trig();
        repeat (30) @(negedge clk);
        pulse_trig();
        chk(busy, "R2 busy during frame", busy, 1);
        wait_idle();
        chk(frames - f0 == 2, "R9 collapsed pending frames", frames - f0, 2);
        chk(last_gap == EXP_POST + 1, "R8 back-to-back spacing", last_gap, EXP_POST + 1);

        // R9: trigger during the quiet interval
        f0 = frames;
        queue_read(12'h777, 4'h3);
        queue_read(12'h0F0, 4'hC);
        pulse_trig();
        while (!valid) @(negedge clk);
        repeat (3) @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        chk(cs_n && busy, "R9 pending held in quiet interval", {cs_n, busy}, 3);
        wait_idle();
        chk(frames - f0 == 2, "R9 frame after quiet interval", frames - f0, 2);
        chk(last_gap == EXP_POST + 1, "R8 spacing after quiet trigger", last_gap, EXP_POST + 1);

        chk(exp_q.size() == 0, "R6 all results delivered", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule